// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block decides which of eight interrupt request lines, if any, should interrupt the processor right now. It takes a vector of pending requests and a vector of mask bits. It ranks the unmasked requests against a rotating base: the line equal to the base is the most urgent, and urgency falls as the line number counts upward from it, wrapping past the top. A request raises the interrupt output only if it is strictly more urgent than the most urgent line already being serviced.

The block holds two pieces of state: the in-service register and the 3-bit rotation base. An acknowledge from the processor marks the chosen line as in service. Alternatively, in automatic end-of-interrupt mode, the acknowledge marks nothing and may instead rotate the base. End-of-interrupt commands, in specific, nonspecific and rotating forms, retire lines and move the base.

Two modes change which in-service bits are compared. Special mask mode drops in-service bits whose lines are masked. Special fully nested mode, on the primary instance, drops the cascade line's in-service bit.

The decision logic is combinational from the registered state and the inputs. Register decoding, the initialization sequence and vector generation belong to the surrounding logic.

Top module: `prio_resolver_top`

## Requirements
- R1: An unmasked request on line L has rank (L - base) mod 8, where rank 0 is the most urgent. `irq_o` is low when no request is both pending and unmasked. When `irq_o` is high, `line_o` is the line with the lowest rank, and that line is pending and unmasked.
- R2: `irq_o` is high only when the best pending unmasked rank is strictly lower than the best rank among the counted in-service bits. An equal or worse rank gives no interrupt.
- R3: While `smm_i` is 1, in-service bits whose mask bit is set are left out of the in-service comparison.
- R4: While `sfnm_i` is 1, on a primary instance (parameter PRIMARY=1), in-service bit 2 (the cascade line) is left out of the in-service comparison.
- R5: A cycle with `ack_i`=1, `irq_o`=1, `cmd_valid_i`=0 and `aeoi_i`=0 sets in-service bit `line_o` at the clock edge. An acknowledge while `irq_o` is low changes nothing.
- R6: With `aeoi_i`=1, an accepted acknowledge sets no in-service bit. If `rot_aeoi_i`=1 as well, the base becomes `line_o`+1 mod 8.
- R7: Command code 1 (nonspecific end-of-interrupt) clears the in-service bit of lowest rank; the comparison uses all in-service bits, with no mode exclusions. Code 2 does the same and sets the base to that line+1 mod 8. With an empty in-service register, both codes do nothing.
- R8: Command code 3 clears in-service bit `cmd_line_i`. Code 4 does the same and sets the base to `cmd_line_i`+1 mod 8.
- R9: Command code 5 sets the base to `cmd_line_i`+1 mod 8 and leaves the in-service register alone. Codes 0, 6 and 7 do nothing.
- R10: When `cmd_valid_i` and `ack_i` are both high in one cycle, the command executes and the acknowledge is dropped.
- R11: Synchronous reset (`rst_n`=0 at a clock edge) clears the in-service register and sets the base to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 8 | Pending request per line |
| mask_i | input | 8 | Mask per line, 1 = masked |
| smm_i | input | 1 | Special mask mode |
| sfnm_i | input | 1 | Special fully nested mode |
| aeoi_i | input | 1 | Automatic end-of-interrupt on acknowledge |
| rot_aeoi_i | input | 1 | Rotate base on automatic end-of-interrupt |
| ack_i | input | 1 | Processor acknowledge of the current choice |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code (see R7 to R9) |
| cmd_line_i | input | 3 | Line operand of specific and priority commands |
| irq_o | output | 1 | Interrupt to the processor |
| line_o | output | 3 | Chosen line, valid while irq_o is high |
| isr_o | output | 8 | In-service register |

## Verification
Some properties are checked on every cycle:
- the chosen line is always pending and unmasked;
- with no mode exclusions, the chosen line is never already in service;
- an acknowledge sets the chosen bit, or leaves the register unchanged in automatic mode;
- specific end-of-interrupt commands clear their bit;
- a set-priority command, even when an acknowledge collides with it, leaves the in-service register untouched;
- reset empties the register.

The base is not visible at the ports. Its effect on the ranking, after each rotating command and each automatic rotation, therefore shows only through the bench's scenarios, which read the winning line afterwards. The same holds for the special mask and fully nested exclusions, which the bench shows by comparing one in-service state with the mode on and with it off.

// File: rtl/prio_pkg.sv
// Package: shared command codes for the rotating priority resolver.
// Assumes the command code field is three bits wide.
package prio_pkg;

    typedef enum logic [2:0] {
        CMD_NOP          = 3'd0,
        CMD_EOI          = 3'd1,
        CMD_ROT_EOI      = 3'd2,
        CMD_SPEC_EOI     = 3'd3,
        CMD_ROT_SPEC_EOI = 3'd4,
        CMD_SET_BASE     = 3'd5
    } cmd_e;

endpackage

// File: rtl/prio_find.sv
// Module: prio_find
// Finds the set bit of lowest rank in a vector, where rank is the distance
// from a rotation base counted upward modulo N.
// Assumes N is a power of two, so the index wraps by plain truncation.
module prio_find #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    input  logic [W-1:0] base,
    output logic         hit,
    output logic [W-1:0] rank,
    output logic [W-1:0] line
);

    logic [N-1:0] rot;

    // Rotate the vector so that the base line lands at position 0.
    for (genvar g = 0; g < N; g++) begin : g_rot
        logic [W-1:0] src;
        assign src    = W'(g) + base;
        assign rot[g] = vec[src];
    end

    // Pick the lowest set position of the rotated vector.
    always_comb begin
        hit  = 1'b0;
        rank = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (rot[i]) begin
                hit  = 1'b1;
                rank = W'(i);
            end
        end
    end

    // Map the winning rank back to an absolute line number.
    assign line = rank + base;

endmodule

// File: rtl/isr_ctrl.sv
// Module: isr_ctrl
// Holds the in-service register and the rotation base and applies
// acknowledges and end-of-interrupt / priority commands to them.
// Assumes the caller has already qualified the acknowledge: ack_take is high
// only when an interrupt is presented and no command shares the cycle.
module isr_ctrl
    import prio_pkg::*;
#(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ack_take,
    input  logic [W-1:0] ack_line,
    input  logic         aeoi,
    input  logic         rot_aeoi,
    input  logic         cmd_valid,
    input  logic [2:0]   cmd_op,
    input  logic [W-1:0] cmd_line,
    input  logic         top_hit,
    input  logic [W-1:0] top_line,
    output logic [N-1:0] isr_q,
    output logic [W-1:0] base_q
);

    logic [N-1:0] isr_d;
    logic [W-1:0] base_d;

    // Next-state of in-service bits and base; commands win over acknowledge.
    always_comb begin
        isr_d  = isr_q;
        base_d = base_q;
        if (cmd_valid) begin
            case (cmd_e'(cmd_op))
                CMD_EOI: begin
                    if (top_hit) isr_d[top_line] = 1'b0;
                end
                CMD_ROT_EOI: begin
                    if (top_hit) begin
                        isr_d[top_line] = 1'b0;
                        base_d          = top_line + W'(1);
                    end
                end
                CMD_SPEC_EOI: begin
                    isr_d[cmd_line] = 1'b0;
                end
                CMD_ROT_SPEC_EOI: begin
                    isr_d[cmd_line] = 1'b0;
                    base_d          = cmd_line + W'(1);
                end
                CMD_SET_BASE: begin
                    base_d = cmd_line + W'(1);
                end
                default: ;
            endcase
        end else if (ack_take) begin
            if (!aeoi)         isr_d[ack_line] = 1'b1;
            else if (rot_aeoi) base_d          = ack_line + W'(1);
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q  <= '0;
            base_q <= '0;
        end else begin
            isr_q  <= isr_d;
            base_q <= base_d;
        end
    end

endmodule

// File: rtl/prio_resolver_top.sv
// Module: prio_resolver_top
// Rotating priority interrupt resolver with in-service tracking. Three
// rank finders share the rotation base: one for pending unmasked requests,
// one for the in-service bits that count for blocking, one for the raw
// in-service register (used by nonspecific end-of-interrupt).
// Assumes the request vector is already latched by the surrounding logic.
module prio_resolver_top #(
    parameter int N       = 8,
    parameter int CASCADE = 2,
    parameter bit PRIMARY = 1'b1,
    localparam int W      = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] mask_i,
    input  logic         smm_i,
    input  logic         sfnm_i,
    input  logic         aeoi_i,
    input  logic         rot_aeoi_i,
    input  logic         ack_i,
    input  logic         cmd_valid_i,
    input  logic [2:0]   cmd_op_i,
    input  logic [W-1:0] cmd_line_i,
    output logic         irq_o,
    output logic [W-1:0] line_o,
    output logic [N-1:0] isr_o
);

    logic [N-1:0] isr_q;
    logic [W-1:0] base_q;
    logic [N-1:0] cascade_ex;
    logic [N-1:0] svc_vec;
    logic         pend_hit, svc_hit, top_hit;
    logic [W-1:0] pend_rank, svc_rank, top_rank;
    logic [W-1:0] pend_line, svc_line, top_line;
    logic         ack_take;

    // Cascade exclusion exists only on a primary instance.
    if (PRIMARY) begin : g_primary
        assign cascade_ex = sfnm_i ? (N'(1) << CASCADE) : '0;
    end else begin : g_secondary
        assign cascade_ex = '0;
    end

    // In-service bits that count for blocking new requests.
    assign svc_vec = isr_q & ~(smm_i ? mask_i : '0) & ~cascade_ex;

    prio_find #(.N(N), .W(W)) u_pend (
        .vec(req_i & ~mask_i), .base(base_q),
        .hit(pend_hit), .rank(pend_rank), .line(pend_line)
    );

    prio_find #(.N(N), .W(W)) u_svc (
        .vec(svc_vec), .base(base_q),
        .hit(svc_hit), .rank(svc_rank), .line(svc_line)
    );

    prio_find #(.N(N), .W(W)) u_top (
        .vec(isr_q), .base(base_q),
        .hit(top_hit), .rank(top_rank), .line(top_line)
    );

    // Interrupt only when the request strictly beats the current service.
    assign irq_o    = pend_hit && (!svc_hit || (pend_rank < svc_rank));
    assign line_o   = pend_line;
    assign ack_take = ack_i && irq_o && !cmd_valid_i;
    assign isr_o    = isr_q;

    isr_ctrl #(.N(N), .W(W)) u_isr (
        .clk(clk), .rst_n(rst_n),
        .ack_take(ack_take), .ack_line(pend_line),
        .aeoi(aeoi_i), .rot_aeoi(rot_aeoi_i),
        .cmd_valid(cmd_valid_i), .cmd_op(cmd_op_i), .cmd_line(cmd_line_i),
        .top_hit(top_hit), .top_line(top_line),
        .isr_q(isr_q), .base_q(base_q)
    );

    // Debug-only view of ranks kept out of the outputs.
    logic unused_ok;
    assign unused_ok = ^{top_rank, svc_line};

endmodule

// File: rtl/prio_resolver_chk.sv
// Module: prio_resolver_chk
// Cycle-by-cycle properties of the resolver, observed at its ports only.
// Assumes eight lines and a synchronous active-low reset.
module prio_resolver_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] req_i,
    input logic [7:0] mask_i,
    input logic       smm_i,
    input logic       sfnm_i,
    input logic       aeoi_i,
    input logic       ack_i,
    input logic       cmd_valid_i,
    input logic [2:0] cmd_op_i,
    input logic [2:0] cmd_line_i,
    input logic       irq_o,
    input logic [2:0] line_o,
    input logic [7:0] isr_o
);

    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_i & ~mask_i) == 8'h00) |-> !irq_o);

    a_r1_line_is_live: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (req_i[line_o] && !mask_i[line_o]));

    a_r2_not_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !smm_i && !sfnm_i) |-> !isr_o[line_o]);

    a_r5_ack_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && !cmd_valid_i && !aeoi_i) |=> isr_o[$past(line_o)]);

    a_r6_auto_no_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o && !cmd_valid_i && aeoi_i) |=> $stable(isr_o));

    a_r7_empty_eoi: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && (cmd_op_i == 3'd1 || cmd_op_i == 3'd2) && isr_o == 8'h00)
        |=> (isr_o == 8'h00));

    a_r8_spec_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && (cmd_op_i == 3'd3 || cmd_op_i == 3'd4))
        |=> !isr_o[$past(cmd_line_i)]);

    a_r10_cmd_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_op_i == 3'd5) |=> $stable(isr_o));

    a_r11_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (isr_o == 8'h00));

endmodule

bind prio_resolver_top prio_resolver_chk chk_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_i(mask_i),
    .smm_i(smm_i), .sfnm_i(sfnm_i), .aeoi_i(aeoi_i), .ack_i(ack_i),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_line_i(cmd_line_i),
    .irq_o(irq_o), .line_o(line_o), .isr_o(isr_o)
);

// File: tb/prio_resolver_top_tb_top.sv
// Bench: walks a vector table of stimulus and expected results, then runs
// directed reset and acknowledge corner cases.
module prio_resolver_top_tb_top;

    typedef struct packed {
        logic [7:0] req;
        logic [7:0] mask;
        logic [3:0] mode;   // {smm, sfnm, aeoi, rot_aeoi}
        logic       ack;
        logic       cv;
        logic [2:0] op;
        logic [2:0] line;
        logic       eirq;
        logic [2:0] eline;
        logic [7:0] eisr;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t TBL [NV] = '{
        '{8'h00, 8'h00, 4'b0000, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 8'h00, 4'd1},  // R1 idle
        '{8'h88, 8'h00, 4'b0000, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 3'd3, 8'h00, 4'd1},  // R1 base 0
        '{8'h88, 8'h08, 4'b0000, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 3'd7, 8'h00, 4'd1},  // R1 masked
        '{8'h88, 8'h00, 4'b0000, 1'b1, 1'b0, 3'd0, 3'd0, 1'b1, 3'd3, 8'h08, 4'd5},  // R5 ack
        '{8'h88, 8'h00, 4'b0000, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 8'h08, 4'd2},  // R2 equal
        '{8'h8A, 8'h00, 4'b0000, 1'b1, 1'b0, 3'd0, 3'd0, 1'b1, 3'd1, 8'h0A, 4'd2},  // R2 nest
        '{8'h00, 8'h00, 4'b0000, 1'b0, 1'b1, 3'd1, 3'd0, 1'b0, 3'd0, 8'h08, 4'd7},  // R7 eoi
        '{8'h00, 8'h00, 4'b0000, 1'b0, 1'b1, 3'd3, 3'd3, 1'b0, 3'd0, 8'h00, 4'd8},  // R8 spec
        '{8'h00, 8'h00, 4'b0000, 1'b0, 1'b1, 3'd5, 3'd4, 1'b0, 3'd0, 8'h00, 4'd9},  // R9 base 5
        '{8'h11, 8'h00, 4'b0000, 1'b1, 1'b0, 3'd0, 3'd0, 1'b1, 3'd0, 8'h01, 4'd9},  // R9 effect
        '{8'h10, 8'h00, 4'b0000, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 8'h01, 4'd2},  // R2 worse
        '{8'h00, 8'h00, 4'b0000, 1'b0, 1'b1, 3'd2, 3'd0, 1'b0, 3'd0, 8'h00, 4'd7},  // R7 rot
        '{8'h81, 8'h00, 4'b0000, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 3'd7, 8'h00, 4'd7},  // R7 base 1
        '{8'h81, 8'h00, 4'b0000, 1'b0, 1'b1, 3'd4, 3'd6, 1'b1, 3'd7, 8'h00, 4'd8},  // R8 rot
        '{8'h81, 8'h00, 4'b0000, 1'b1, 1'b0, 3'd0, 3'd0, 1'b1, 3'd7, 8'h80, 4'd8},  // R8 base 7
        '{8'h01, 8'h80, 4'b1000, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 3'd0, 8'h80, 4'd3},  // R3 on
        '{8'h01, 8'h80, 4'b0000, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 8'h80, 4'd3},  // R3 off
        '{8'h00, 8'h00, 4'b0000, 1'b0, 1'b1, 3'd3, 3'd7, 1'b0, 3'd0, 8'h00, 4'd8},  // R8
        '{8'h00, 8'h00, 4'b0000, 1'b0, 1'b1, 3'd5, 3'd7, 1'b0, 3'd0, 8'h00, 4'd9},  // R9 base 0
        '{8'h04, 8'h00, 4'b0000, 1'b1, 1'b0, 3'd0, 3'd0, 1'b1, 3'd2, 8'h04, 4'd5},  // R5
        '{8'h04, 8'h00, 4'b0000, 1'b0, 1'b0, 3'd0, 3'd0, 1'b0, 3'd0, 8'h04, 4'd4},  // R4 off
        '{8'h04, 8'h00, 4'b0100, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 3'd2, 8'h04, 4'd4},  // R4 on
        '{8'h00, 8'h00, 4'b0000, 1'b0, 1'b1, 3'd3, 3'd2, 1'b0, 3'd0, 8'h00, 4'd8},  // R8
        '{8'h20, 8'h00, 4'b0010, 1'b1, 1'b0, 3'd0, 3'd0, 1'b1, 3'd5, 8'h00, 4'd6},  // R6 auto
        '{8'h21, 8'h00, 4'b0011, 1'b1, 1'b0, 3'd0, 3'd0, 1'b1, 3'd0, 8'h00, 4'd6},  // R6 rotate
        '{8'h21, 8'h00, 4'b0000, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 3'd5, 8'h00, 4'd6},  // R6 base 1
        '{8'h21, 8'h00, 4'b0000, 1'b1, 1'b1, 3'd5, 3'd7, 1'b1, 3'd5, 8'h00, 4'd10}, // R10 clash
        '{8'h21, 8'h00, 4'b0000, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 3'd0, 8'h00, 4'd10}, // R10 base 0
        '{8'h21, 8'h00, 4'b0000, 1'b0, 1'b1, 3'd1, 3'd0, 1'b1, 3'd0, 8'h00, 4'd7},  // R7 empty
        '{8'h21, 8'h00, 4'b0000, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 3'd0, 8'h00, 4'd7}   // R7 unchanged
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_i = '0, mask_i = '0;
    logic       smm_i = 0, sfnm_i = 0, aeoi_i = 0, rot_aeoi_i = 0;
    logic       ack_i = 0, cmd_valid_i = 0;
    logic [2:0] cmd_op_i = '0, cmd_line_i = '0;
    logic       irq_o;
    logic [2:0] line_o;
    logic [7:0] isr_o;
    int         n_chk = 0, n_fail = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    prio_resolver_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_i(mask_i),
        .smm_i(smm_i), .sfnm_i(sfnm_i), .aeoi_i(aeoi_i), .rot_aeoi_i(rot_aeoi_i),
        .ack_i(ack_i), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
        .cmd_line_i(cmd_line_i), .irq_o(irq_o), .line_o(line_o), .isr_o(isr_o)
    );

    task automatic check(input bit ok, input int rq, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Drive one vector at a falling edge, check combinational outputs, then
    // the in-service register after the next rising edge.
    task automatic apply(input vec_t v);
        @(negedge clk);
        req_i = v.req; mask_i = v.mask;
        {smm_i, sfnm_i, aeoi_i, rot_aeoi_i} = v.mode;
        ack_i = v.ack; cmd_valid_i = v.cv; cmd_op_i = v.op; cmd_line_i = v.line;
        #1;
        check(irq_o == v.eirq, int'(v.rq), "irq", int'(irq_o), int'(v.eirq));
        if (v.eirq)
            check(line_o == v.eline, int'(v.rq), "line", int'(line_o), int'(v.eline));
        @(negedge clk);
        check(isr_o == v.eisr, int'(v.rq), "isr", int'(isr_o), int'(v.eisr));
        ack_i = 0; cmd_valid_i = 0; cmd_op_i = '0;
    endtask

    function automatic vec_t mk(input logic [7:0] req, input logic ack,
                                input logic cv, input logic [2:0] op,
                                input logic [2:0] line, input logic eirq,
                                input logic [2:0] eline, input logic [7:0] eisr,
                                input logic [3:0] rq);
        return '{req, 8'h00, 4'b0000, ack, cv, op, line, eirq, eline, eisr, rq};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check(isr_o == 8'h00, 11, "reset isr", int'(isr_o), 0);
        check(irq_o == 1'b0, 11, "reset irq", int'(irq_o), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) apply(TBL[i]);

        // R11: reset in the middle of service restores base 0 and empties isr
        apply(mk(8'h40, 1, 0, 3'd0, 3'd0, 1, 3'd6, 8'h40, 4'd5));
        apply(mk(8'h00, 0, 1, 3'd5, 3'd3, 0, 3'd0, 8'h40, 4'd9));
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(isr_o == 8'h00, 11, "mid reset isr", int'(isr_o), 0);
        apply(mk(8'h41, 0, 0, 3'd0, 3'd0, 1, 3'd0, 8'h00, 4'd11));

        // R5: acknowledge without a presented interrupt has no effect
        apply(mk(8'h02, 1, 0, 3'd0, 3'd0, 1, 3'd1, 8'h02, 4'd5));
        apply(mk(8'h00, 1, 0, 3'd0, 3'd0, 0, 3'd0, 8'h02, 4'd5));
        apply(mk(8'h02, 1, 0, 3'd0, 3'd0, 0, 3'd0, 8'h02, 4'd5));

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R11 watchdog expired: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule